// File: doc/BRIEF.md
# Chained Mask/Value Trigger Sequencer

This block watches a stream of multi-channel logic samples and decides when a capture may begin. It holds a small bank of trigger stages. Each stage selects the channels it cares about with a mask, names the level each selected channel must show with a value word, and carries a configuration word that gives the stage's sequence level and a start flag. A run strobe arms the first stage. Each qualified sample is compared only against the armed stage. A match on a stage without the start flag arms the next stage. A match on a stage with the start flag raises a one-clock trigger pulse and returns the unit to idle.

Software or a command decoder loads the stage registers through a simple write port. The port takes a stage index, a field select and a data word. When no real trigger is wanted, stage 0 is loaded with an empty mask and the start flag, so the first qualified sample after the run strobe starts the capture.

Top module: `trig_seq_unit`

## Requirements
- R1: After reset, trig_pulse is 0, active_stage is 0, running is 0, and every stage register holds zero.
- R2: A run strobe sampled at a clock edge sets running to 1 and active_stage to 0 from that edge on.
- R3: A channel takes part in a stage's comparison only when its mask bit is 1. It then matches when the sample bit equals the value bit (0 = low, 1 = high). A stage whose mask is all zero matches any sample.
- R4: Samples are compared only on edges where sample_en is 1. With sample_en low, the state does not change.
- R5: Bits 23:16 of a stage's configuration word hold its level. Stage k can match only when this level equals k.
- R6: Bit 27 of the configuration word is the start flag. If the armed stage matches and its flag is set, trig_pulse is 1 for exactly one clock after that edge, and running drops to 0 at the same edge.
- R7: If the armed stage matches and its flag is clear, active_stage advances by one at that edge. At the last stage it stays where it is and no pulse is produced.
- R8: A write with cfg_we=1 updates the field of stage cfg_stage chosen by cfg_sel: 0 is mask, 1 is value, 2 is configuration. cfg_sel=3 changes nothing.
- R9: With stage 0 set to an all-zero mask, level 0 and the start flag, the first qualified sample after the run strobe produces the pulse.
- R10: After firing, the unit stays idle until the next run strobe. A run strobe while running restarts at stage 0. A run strobe takes priority over a match at the same edge, so that edge produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Arms stage 0 and starts the sequence |
| sample_en | input | 1 | Marks the clock where sample is valid |
| sample | input | 32 | Channel sample word |
| cfg_we | input | 1 | Stage register write enable |
| cfg_stage | input | 2 | Stage index for the write |
| cfg_sel | input | 2 | Field select: 0 mask, 1 value, 2 configuration |
| cfg_data | input | 32 | Write data |
| trig_pulse | output | 1 | One-clock capture start pulse |
| active_stage | output | 2 | Index of the armed stage |
| running | output | 1 | Sequence armed and waiting |

## Verification
Every result is registered once. A run strobe, a match, an advance or a pulse shows on the ports in the clock that follows the edge where the inputs were sampled. A register write affects comparisons only from the next edge on. The bench drives inputs on the falling edge. Its behavioural model updates on the rising edge from those same inputs. The bench compares the outputs against the model on the next falling edge, half a period after they changed. Directed checks for each scenario are sampled one falling edge after the stimulus edge. This is the point where the pulse, stage index or running flag is due.

// File: rtl/trig_pkg.sv
package trig_pkg;
    parameter int CHANNELS  = 32;
    parameter int CONF_W    = 32;
    localparam int LEVEL_LSB = 16;
    localparam int LEVEL_W   = 8;
    localparam int START_BIT = 27;

    typedef enum logic [1:0] {
        SEL_MASK  = 2'd0,
        SEL_VALUE = 2'd1,
        SEL_CONF  = 2'd2,
        SEL_NONE  = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic [CHANNELS-1:0] mask;
        logic [CHANNELS-1:0] value;
        logic [CONF_W-1:0]   conf;
    } stage_cfg_t;

    function automatic logic word_hit(input logic [CHANNELS-1:0] smp,
                                      input logic [CHANNELS-1:0] mask,
                                      input logic [CHANNELS-1:0] value);
        return ~|((smp ^ value) & mask);
    endfunction

    function automatic logic [LEVEL_W-1:0] conf_level(input logic [CONF_W-1:0] c);
        return c[LEVEL_LSB +: LEVEL_W];
    endfunction
endpackage

// File: rtl/trig_stage_regs.sv
module trig_stage_regs
    import trig_pkg::*;
#(
    parameter int STAGES = 4,
    localparam int SW = (STAGES > 1) ? $clog2(STAGES) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [SW-1:0]       stage,
    input  logic [1:0]          sel,
    input  logic [CHANNELS-1:0] data,
    output stage_cfg_t          cfg_q [STAGES]
);
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic hit_me;
        assign hit_me = we && (stage == SW'(s));
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[s] <= '0;
            end else if (hit_me) begin
                case (cfg_sel_e'(sel))
                    SEL_MASK:  cfg_q[s].mask  <= data;
                    SEL_VALUE: cfg_q[s].value <= data;
                    SEL_CONF:  cfg_q[s].conf  <= CONF_W'(data);
                    default:   ;
                endcase
            end
        end
    end
endmodule

// File: rtl/trig_match.sv
module trig_match
    import trig_pkg::*;
#(
    parameter int STAGES = 4
) (
    input  logic [CHANNELS-1:0] sample,
    input  stage_cfg_t          cfg_q [STAGES],
    output logic [STAGES-1:0]   hit,
    output logic [STAGES-1:0]   start
);
    for (genvar s = 0; s < STAGES; s++) begin : g_cmp
        logic lvl_ok;
        assign lvl_ok   = (conf_level(cfg_q[s].conf) == LEVEL_W'(s));
        assign hit[s]   = lvl_ok && word_hit(sample, cfg_q[s].mask, cfg_q[s].value);
        assign start[s] = cfg_q[s].conf[START_BIT];
    end
endmodule

// File: rtl/trig_sequencer.sv
module trig_sequencer #(
    parameter int STAGES = 4,
    localparam int SW = (STAGES > 1) ? $clog2(STAGES) : 1,
    localparam logic [SW-1:0] LAST = SW'(STAGES - 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              sample_en,
    input  logic [STAGES-1:0] hit,
    input  logic [STAGES-1:0] start,
    output logic [SW-1:0]     active,
    output logic              running,
    output logic              pulse
);
    logic take;
    assign take = running && sample_en && hit[active];

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= '0;
            running <= 1'b0;
            pulse   <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (run) begin
                running <= 1'b1;
                active  <= '0;
            end else if (take) begin
                if (start[active]) begin
                    pulse   <= 1'b1;
                    running <= 1'b0;
                end else if (active != LAST) begin
                    active <= active + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/trig_seq_unit.sv
module trig_seq_unit
    import trig_pkg::*;
#(
    parameter int STAGES = 4,
    localparam int SW = (STAGES > 1) ? $clog2(STAGES) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic                sample_en,
    input  logic [CHANNELS-1:0] sample,
    input  logic                cfg_we,
    input  logic [SW-1:0]       cfg_stage,
    input  logic [1:0]          cfg_sel,
    input  logic [CHANNELS-1:0] cfg_data,
    output logic                trig_pulse,
    output logic [SW-1:0]       active_stage,
    output logic                running
);
    stage_cfg_t        cfg_q [STAGES];
    logic [STAGES-1:0] hit;
    logic [STAGES-1:0] start;

    trig_stage_regs #(.STAGES(STAGES)) i_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .stage(cfg_stage),
        .sel(cfg_sel), .data(cfg_data), .cfg_q(cfg_q)
    );

    trig_match #(.STAGES(STAGES)) i_match (
        .sample(sample), .cfg_q(cfg_q), .hit(hit), .start(start)
    );

    trig_sequencer #(.STAGES(STAGES)) i_seq (
        .clk(clk), .rst(rst), .run(run), .sample_en(sample_en),
        .hit(hit), .start(start), .active(active_stage),
        .running(running), .pulse(trig_pulse)
    );
endmodule

// File: rtl/trig_seq_chk.sv
module trig_seq_chk #(
    parameter int SW = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          run,
    input logic          sample_en,
    input logic          trig_pulse,
    input logic [SW-1:0] active_stage,
    input logic          running
);
    // R6
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |=> !trig_pulse);

    // R6
    pulse_cause_chk: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |-> ($past(running && sample_en && !run) && !running));

    // R2
    run_arm_chk: assert property (@(posedge clk) disable iff (rst)
        run |=> (running && active_stage == '0));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!sample_en && !run) |=> ($stable(active_stage) && $stable(running) && !trig_pulse));

    // R7
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (running && sample_en && !run) |=>
            (active_stage == $past(active_stage) || active_stage == $past(active_stage) + 1'b1));

    // R10
    idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!running && !run) |=> (!running && !trig_pulse));
endmodule

bind trig_seq_unit trig_seq_chk #(.SW(SW)) i_chk (
    .clk(clk), .rst(rst), .run(run), .sample_en(sample_en),
    .trig_pulse(trig_pulse), .active_stage(active_stage), .running(running)
);

// File: tb/test_trig_seq_unit.sv
module test_trig_seq_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic        sample_en = 1'b0;
    logic [31:0] sample = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_stage = '0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_data = '0;
    logic        trig_pulse;
    logic [1:0]  active_stage;
    logic        running;

    int checks = 0;
    int fails = 0;
    int pulses = 0;
    bit done = 0;

    always #2 clk = ~clk;

    trig_seq_unit i_trig_seq_unit (
        .clk(clk), .rst(rst), .run(run), .sample_en(sample_en), .sample(sample),
        .cfg_we(cfg_we), .cfg_stage(cfg_stage), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .trig_pulse(trig_pulse), .active_stage(active_stage), .running(running)
    );

    // behavioural reference model
    logic [31:0] m_mask [4];
    logic [31:0] m_val  [4];
    logic [31:0] m_conf [4];
    int m_act = 0;
    bit m_run = 0;
    bit m_pulse = 0;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4; i++) begin
                m_mask[i] = 0; m_val[i] = 0; m_conf[i] = 0;
            end
            m_act = 0; m_run = 0; m_pulse = 0;
        end else begin
            m_pulse = 0;
            if (run) begin
                m_run = 1; m_act = 0;
            end else if (m_run && sample_en &&
                         (((sample ^ m_val[m_act]) & m_mask[m_act]) == 0) &&
                         (m_conf[m_act][23:16] == m_act)) begin
                if (m_conf[m_act][27]) begin
                    m_pulse = 1; m_run = 0;
                end else if (m_act < 3) begin
                    m_act = m_act + 1;
                end
            end
            if (cfg_we) begin
                if (cfg_sel == 0) m_mask[cfg_stage] = cfg_data;
                else if (cfg_sel == 1) m_val[cfg_stage] = cfg_data;
                else if (cfg_sel == 2) m_conf[cfg_stage] = cfg_data;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (trig_pulse) pulses++;
            check(trig_pulse == m_pulse, "R6", "pulse vs model", int'(trig_pulse), int'(m_pulse));
            check(active_stage == m_act[1:0], "R7", "stage vs model", int'(active_stage), m_act);
            check(running == m_run, "R10", "running vs model", int'(running), int'(m_run));
        end
    end

    task automatic idle_drive();
        run = 0; sample_en = 0; cfg_we = 0;
    endtask

    task automatic wr(input int stg, input int sel, input logic [31:0] d);
        @(negedge clk);
        idle_drive();
        cfg_we = 1; cfg_stage = 2'(stg); cfg_sel = 2'(sel); cfg_data = d;
    endtask

    task automatic do_run();
        @(negedge clk);
        idle_drive();
        run = 1;
    endtask

    task automatic smp(input logic [31:0] d, input bit en);
        @(negedge clk);
        idle_drive();
        sample = d; sample_en = en;
    endtask

    task automatic settle();
        @(negedge clk);
        idle_drive();
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired: actual 0 expected 1");
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int p0;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R1 reset state
        check(trig_pulse == 0, "R1", "pulse after reset", int'(trig_pulse), 0);
        check(active_stage == 0, "R1", "stage after reset", int'(active_stage), 0);
        check(running == 0, "R1", "running after reset", int'(running), 0);
        // R1 zero registers: level 0, mask 0, no flag -> stage 0 advances
        do_run(); smp(32'hDEAD_BEEF, 1); settle();
        check(active_stage == 1, "R1", "zero regs advance", int'(active_stage), 1);

        // R9 forced start
        wr(0, 2, 32'h0800_0000);
        do_run(); settle();
        check(running == 1 && active_stage == 0, "R2", "armed after run", int'(running), 1);
        p0 = pulses;
        smp(32'h1234_5678, 1);
        @(negedge clk); idle_drive(); #1;
        check(trig_pulse == 1, "R9", "forced pulse", int'(trig_pulse), 1);
        check(running == 0, "R6", "idle after fire", int'(running), 0);
        settle();
        check(trig_pulse == 0, "R6", "pulse one clock", int'(trig_pulse), 0);
        smp(32'h0, 1); smp(32'hFFFF_FFFF, 1); settle();
        check(pulses == p0 + 1, "R10", "no refire when idle", pulses, p0 + 1);

        // R3 / R7 chain of three stages
        wr(0, 0, 32'h0000_00FF); wr(0, 1, 32'h0000_0012); wr(0, 2, 32'h0000_0000);
        wr(1, 0, 32'h0000_FF00); wr(1, 1, 32'h0000_3400); wr(1, 2, 32'h0001_0000);
        wr(2, 0, 32'h0000_000F); wr(2, 1, 32'h0000_0005); wr(2, 2, 32'h0802_0000);
        do_run();
        smp(32'hFFFF_FF13, 1); settle();
        check(active_stage == 0, "R3", "masked mismatch holds", int'(active_stage), 0);
        smp(32'hABCD_EF12, 1); settle();
        check(active_stage == 1, "R7", "advance to stage 1", int'(active_stage), 1);
        // R4: matching sample without sample_en
        smp(32'h0000_3400, 0); settle();
        check(active_stage == 1, "R4", "no compare without enable", int'(active_stage), 1);
        smp(32'h0000_0005, 1); settle();
        check(active_stage == 1, "R3", "stage 2 pattern ignored at stage 1", int'(active_stage), 1);
        smp(32'hFFFF_34FF, 1); settle();
        check(active_stage == 2, "R7", "advance to stage 2", int'(active_stage), 2);
        p0 = pulses;
        smp(32'h0000_00F5, 1);
        @(negedge clk); idle_drive(); #1;
        check(trig_pulse == 1, "R6", "final stage pulse", int'(trig_pulse), 1);
        settle();

        // R5 level mismatch on stage 0
        wr(0, 0, 32'h0); wr(0, 2, 32'h0801_0000);
        do_run(); smp(32'h0, 1); smp(32'h5, 1); settle();
        check(active_stage == 0 && running == 1, "R5", "wrong level never matches", int'(active_stage), 0);
        // R8 select 3 writes nothing
        wr(0, 3, 32'h0800_0000); smp(32'h0, 1); settle();
        check(running == 1 && pulses == p0 + 1, "R8", "sel 3 ignored", pulses, p0 + 1);
        wr(0, 2, 32'h0800_0000); smp(32'h0, 1); settle();
        check(pulses == p0 + 2, "R8", "conf write takes effect", pulses, p0 + 2);

        // R7 last stage without flag stays
        wr(0, 2, 32'h0000_0000);
        wr(1, 0, 32'h0); wr(1, 2, 32'h0001_0000);
        wr(2, 0, 32'h0); wr(2, 2, 32'h0002_0000);
        wr(3, 2, 32'h0003_0000);
        do_run();
        for (int k = 0; k < 6; k++) smp(32'(k), 1);
        settle();
        check(active_stage == 3 && running == 1, "R7", "last stage holds", int'(active_stage), 3);
        // R10 rerun while running
        do_run(); settle();
        check(active_stage == 0, "R10", "rerun restarts", int'(active_stage), 0);

        // R10 run beats match at the same edge
        wr(0, 2, 32'h0800_0000);
        p0 = pulses;
        @(negedge clk); idle_drive(); run = 1; sample_en = 1; sample = 0;
        settle();
        check(trig_pulse == 0 && running == 1, "R10", "run has priority", int'(trig_pulse), 0);
        smp(32'h0, 1); settle(); settle();
        check(pulses == p0 + 1, "R10", "fires after priority edge", pulses, p0 + 1);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule